// File: doc/BRIEF.md
# Integer ALU with Compare and Bit-Count

This block is the integer execution stage for three instruction groups of a 32-bit core: arithmetic (add, subtract, set-less-than, add-to-PC), logic and bit counting (AND, OR, XOR, NAND, population count, leading-ones count, highest-set-bit index), and compares that produce a single true/false flag. The decoder hands it a 4-bit group code, a 4-bit opcode, two operands and the current PC. When an instruction carries an immediate, the decoder has already sign-extended and shifted it, and it arrives on the second operand.

All results are computed combinationally from the inputs. They are captured in one output register stage, so every output reflects the inputs sampled at the previous rising clock edge. Compares never produce a register result. Instead they raise a flag-write strobe together with the condition outcome. Encodings the block does not handle (multiply, divide, remainder, no-op and unassigned codes) come out as an idle cycle: no valid result, a zero result, and no flag write.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low, and at the first sampling point after it is released, all outputs are zero.
- R2: Group 4'h0. Opcode low bits 3'b000 give `a + b`. Opcode 4'b1110 gives `a - b`. Low bits 3'b111 give `pc + b`. All results wrap modulo 2^32 and are flagged valid.
- R3: Group 4'h0. Low bits 3'b100 give 1 if `a < b` as two's-complement values, else 0. Low bits 3'b101 do the same with an unsigned comparison. The result is flagged valid.
- R4: Group 4'h1. Low bits 3'b000, 3'b001, 3'b010 and 3'b011 give AND, OR, XOR and NAND of `a` and `b`. Opcode bit 3 makes no difference. The result is flagged valid.
- R5: Group 4'h1, opcode 4'b1100: the result is the number of set bits in `a` (0 to 32), flagged valid.
- R6: Group 4'h1, opcode 4'b1101: the result is the length of the unbroken run of ones starting at bit 31 of `a` (0 to 32), flagged valid.
- R7: Group 4'h1, opcode 4'b1110: the result is the index of the highest set bit of `a`. When `a` is zero the result is 32'hFFFFFFFF. The result is flagged valid.
- R8: Group 4'h2. Low bits 3'b000 select EQ, 3'b001 select unsigned `a<b`, 3'b010 select unsigned `a<=b`, 3'b011 select signed `a<b`, and 3'b100 select signed `a<=b`. Opcode bit 3 is ignored. The flag output carries the outcome with its write strobe high, while the result is 0 and not valid.
- R9: These encodings produce result 0, valid low, flag 0 and strobe low: group 4'h0 with low bits 001/010/011 or opcode 4'b0110; group 4'h1 with opcodes 4'b0100 to 4'b0111 or 4'b1111; group 4'h2 with low bits 101 to 111; any group from 4'h3 to 4'hF.
- R10: Every output reflects the inputs present at the preceding rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_i | input | 4 | Instruction group code |
| op_i | input | 4 | Opcode within the group |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand or pre-expanded immediate |
| pc_i | input | 32 | Address of the current instruction |
| res_o | output | 32 | Registered result |
| res_vld_o | output | 1 | Result is to be written back |
| tflag_o | output | 1 | Compare outcome |
| tflag_we_o | output | 1 | Compare outcome is to be written to the flag |

## Verification
The bench sweeps every group and opcode against operands at the sign boundary, all ones, zero and equal pairs, because these are where a signed and an unsigned compare disagree. A design that swapped the two would return the wrong set-less-than value or flag exactly on the 32'h80000000 and 32'h7FFFFFFF pairs. Zero, all-ones and single-high-bit operands on the bit-count operations expose an off-by-one leading-ones count or a leading-one index that returns 0 instead of all ones for a zero input. Sending every unassigned encoding through the sweep catches a decoder that lets stale adder output or a spurious flag strobe leak through on idle codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int XLEN = 32;

    localparam logic [3:0] GRP_ARITH = 4'h0;
    localparam logic [3:0] GRP_LOGIC = 4'h1;
    localparam logic [3:0] GRP_CMP   = 4'h2;

    typedef enum logic [2:0] {
        CND_EQ  = 3'b000,
        CND_LTU = 3'b001,
        CND_LEU = 3'b010,
        CND_LTS = 3'b011,
        CND_LES = 3'b100
    } cmp_cond_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] pc,
    output logic [W-1:0] res,
    output logic         vld
);
    logic [W:0]   diff;
    logic         lt_u;
    logic         lt_s;

    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        lt_u = diff[W];
        lt_s = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];
        res  = '0;
        vld  = 1'b1;
        if (op == 4'b1110) begin
            res = diff[W-1:0];
        end else begin
            case (op[2:0])
                3'b000:  res = a + b;
                3'b100:  res = W'(lt_s);
                3'b101:  res = W'(lt_u);
                3'b111:  res = pc + b;
                default: vld = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu_bits.sv
module alu_bits #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] pop,
    output logic [W-1:0] clo,
    output logic [W-1:0] plo
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] pop_cnt;
    logic [CW-1:0] clo_cnt;
    logic          run;

    always_comb begin
        pop_cnt = '0;
        for (int i = 0; i < W; i++) begin
            pop_cnt = pop_cnt + CW'(a[i]);
        end
        pop = W'(pop_cnt);
    end

    always_comb begin
        clo_cnt = '0;
        run     = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            run = run & a[i];
            clo_cnt = clo_cnt + CW'(run);
        end
        clo = W'(clo_cnt);
    end

    always_comb begin
        plo = '1;
        for (int i = 0; i < W; i++) begin
            if (a[i]) begin
                plo = W'(i);
            end
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         vld
);
    logic [W-1:0] pop_w;
    logic [W-1:0] clo_w;
    logic [W-1:0] plo_w;

    alu_bits #(.W(W)) u_bits (
        .a   (a),
        .pop (pop_w),
        .clo (clo_w),
        .plo (plo_w)
    );

    always_comb begin
        res = '0;
        vld = 1'b1;
        if (op[2] == 1'b0) begin
            case (op[1:0])
                2'b00:   res = a & b;
                2'b01:   res = a | b;
                2'b10:   res = a ^ b;
                default: res = ~(a & b);
            endcase
        end else begin
            case (op)
                4'b1100: res = pop_w;
                4'b1101: res = clo_w;
                4'b1110: res = plo_w;
                default: vld = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         t,
    output logic         we
);
    import alu_pkg::*;

    logic eq;
    logic ltu;
    logic lts;

    always_comb begin
        eq  = (a == b);
        ltu = (a < b);
        lts = ($signed(a) < $signed(b));
        t   = 1'b0;
        we  = 1'b1;
        case (cmp_cond_e'(op[2:0]))
            CND_EQ:  t = eq;
            CND_LTU: t = ltu;
            CND_LEU: t = ltu | eq;
            CND_LTS: t = lts;
            CND_LES: t = lts | eq;
            default: we = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   grp_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] res_o,
    output logic         res_vld_o,
    output logic         tflag_o,
    output logic         tflag_we_o
);
    import alu_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic         vld;
        logic         tflag;
        logic         twe;
    } stage_t;

    stage_t       out_d;
    stage_t       out_q;

    logic [W-1:0] ar_res;
    logic         ar_vld;
    logic [W-1:0] lg_res;
    logic         lg_vld;
    logic         cm_t;
    logic         cm_we;

    alu_arith #(.W(W)) u_arith (
        .op  (op_i),
        .a   (opa_i),
        .b   (opb_i),
        .pc  (pc_i),
        .res (ar_res),
        .vld (ar_vld)
    );

    alu_logic #(.W(W)) u_logic (
        .op  (op_i),
        .a   (opa_i),
        .b   (opb_i),
        .res (lg_res),
        .vld (lg_vld)
    );

    alu_cmp #(.W(W)) u_cmp (
        .op (op_i),
        .a  (opa_i),
        .b  (opb_i),
        .t  (cm_t),
        .we (cm_we)
    );

    always_comb begin
        out_d = '0;
        case (grp_i)
            GRP_ARITH: begin
                out_d.vld = ar_vld;
                out_d.res = ar_vld ? ar_res : '0;
            end
            GRP_LOGIC: begin
                out_d.vld = lg_vld;
                out_d.res = lg_vld ? lg_res : '0;
            end
            GRP_CMP: begin
                out_d.twe   = cm_we;
                out_d.tflag = cm_we & cm_t;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o      = out_q.res;
    assign res_vld_o  = out_q.vld;
    assign tflag_o    = out_q.tflag;
    assign tflag_we_o = out_q.twe;

    AST_CMP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        tflag_we_o |-> (!res_vld_o && res_o == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> res_o == '0); // R9
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tflag_we_o |-> !tflag_o); // R9
    AST_SLT_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp_i == GRP_ARITH && op_i[2:1] == 2'b10) && res_vld_o)
        |-> res_o[W-1:1] == '0); // R3
    AST_POP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp_i == GRP_LOGIC && op_i == 4'b1100) && res_vld_o)
        |-> res_o <= W); // R5
    AST_PLO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp_i == GRP_LOGIC && op_i == 4'b1110 && opa_i == '0) && res_vld_o)
        |-> res_o == '1); // R7
endmodule

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  grp_i = '0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] res_o;
    logic        res_vld_o;
    logic        tflag_o;
    logic        tflag_we_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    bit [34:0] exp_q[$];
    string     tag_q[$];

    always #10 clk = ~clk;

    alu_core u_alu_core (
        .clk(clk), .rst_n(rst_n), .grp_i(grp_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .pc_i(pc_i),
        .res_o(res_o), .res_vld_o(res_vld_o),
        .tflag_o(tflag_o), .tflag_we_o(tflag_we_o)
    );

    // Reference: returns {res, vld, tflag, twe}
    function automatic bit [34:0] model(bit [3:0] g, bit [3:0] o,
                                        bit [31:0] a, bit [31:0] b, bit [31:0] pc);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        bit [31:0] r = 0;
        bit v = 0, t = 0, w = 0;
        int k;
        if (g == 0) begin
            v = 1;
            if (o == 4'b1110) r = 32'(ua - ub);
            else if (o[2:0] == 0) r = 32'(ua + ub);
            else if (o[2:0] == 4) r = (sa < sb) ? 1 : 0;
            else if (o[2:0] == 5) r = (ua < ub) ? 1 : 0;
            else if (o[2:0] == 7) r = 32'(longint'(pc) + ub);
            else v = 0;
        end else if (g == 1) begin
            v = 1;
            if (o[2] == 0) begin
                case (o[1:0])
                    0: r = a & b;
                    1: r = a | b;
                    2: r = a ^ b;
                    default: r = ~(a & b);
                endcase
            end else if (o == 12) begin
                k = 0;
                foreach (a[i]) if (a[i]) k++;
                r = k;
            end else if (o == 13) begin
                k = 0;
                while (k < 32 && a[31-k]) k++;
                r = k;
            end else if (o == 14) begin
                r = 32'hFFFF_FFFF;
                for (int i = 31; i >= 0; i--) if (a[i]) begin r = i; break; end
            end else v = 0;
        end else if (g == 2) begin
            w = 1;
            case (o[2:0])
                0: t = (a == b);
                1: t = (ua < ub);
                2: t = (ua <= ub);
                3: t = (sa < sb);
                4: t = (sa <= sb);
                default: w = 0;
            endcase
        end
        return {r, v, t, w};
    endfunction

    function automatic string tag_of(bit [3:0] g, bit [3:0] o);
        if (g == 0) begin
            if (o == 4'b1110 || o[2:0] == 0 || o[2:0] == 7) return "R2";
            if (o[2:1] == 2'b10) return "R3";
            return "R9";
        end
        if (g == 1) begin
            if (o[2] == 0) return "R4";
            if (o == 12) return "R5";
            if (o == 13) return "R6";
            if (o == 14) return "R7";
            return "R9";
        end
        if (g == 2) return (o[2:0] <= 4) ? "R8" : "R9";
        return "R9";
    endfunction

    task automatic compare(bit [34:0] e, string tg);
        bit [34:0] got = {res_o, res_vld_o, tflag_o, tflag_we_o};
        n_vec++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s/R10: got res=%h vld=%b t=%b we=%b expected res=%h vld=%b t=%b we=%b",
                     tg, got[34:3], got[2], got[1], got[0], e[34:3], e[2], e[1], e[0]);
        end
    endtask

    // Called at a negedge: check the previous vector, then drive a new one.
    task automatic apply(bit [3:0] g, bit [3:0] o, bit [31:0] a, bit [31:0] b, bit [31:0] pc);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        grp_i = g; op_i = o; opa_i = a; opb_i = b; pc_i = pc;
        exp_q.push_back(model(g, o, a, b, pc));
        tag_q.push_back(tag_of(g, o));
        @(negedge clk);
    endtask

    function automatic bit [31:0] pat(int p, bit sel);
        case (p)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return sel ? 32'h7FFF_FFFF : 32'h8000_0000;
            3: return sel ? 32'h8000_0000 : 32'h7FFF_FFFF;
            4: return 32'h1234_5678;
            5: return sel ? 32'h0000_0001 : 32'hF000_0000;
            6: return sel ? 32'hFFFF_FFFF : 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        grp_i = 4'h0; op_i = 4'h0; opa_i = 32'h55; opb_i = 32'h66; pc_i = 32'h100;
        repeat (3) @(negedge clk);
        n_vec++;  // R1: outputs held at zero in reset
        if ({res_o, res_vld_o, tflag_o, tflag_we_o} !== 35'h0) begin
            n_bad++;
            $display("FAIL R1: got res=%h vld=%b t=%b we=%b expected all zero",
                     res_o, res_vld_o, tflag_o, tflag_we_o);
        end
        rst_n = 1'b1;
        for (int p = 0; p < 10; p++) begin
            for (int g = 0; g < 16; g++) begin
                for (int o = 0; o < 16; o++) begin
                    bit [31:0] a = pat(p, 0);
                    bit [31:0] b = (p == 4) ? a : pat(p, 1);
                    apply(4'(g), 4'(o), a, b, $urandom);
                end
            end
        end
        // R6/R7 single-bit and run corners
        for (int i = 0; i < 32; i++) begin
            apply(4'h1, 4'b1101, ~(32'hFFFF_FFFF >> i), 0, 0);
            apply(4'h1, 4'b1110, 32'h1 << i, 0, 0);
        end
        apply(4'h1, 4'b1101, 32'hFFFF_FFFE, 0, 0);
        apply(4'h3, 4'h0, 0, 0, 0);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL R10: watchdog expired, got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule